// File: doc/BRIEF.md
# Line-Frequency Binary Time-of-Day Counter

This block keeps the time of day using the AC supply as its timebase. A pulse train taken from the mains enters asynchronously to the system clock. It is synchronized, and a persistence filter rejects the short spikes that appear near zero crossings. A rising-edge detector then turns each clean line cycle into exactly one single-cycle count enable. A prescaler divides these counts by 6 (60 Hz supply) or by 5 (50 Hz supply) to make tenth-of-second ticks. Cascaded counters hold tenths, seconds, minutes and hours, and all four fields appear as plain binary buses that can drive an LED display directly.

All state is clocked by one system clock, and no counter is clocked by another counter's output. The time is set through a small valid/ready load port. The block accepts a load in any cycle where `set_valid` and `set_ready` are both high. `set_ready` is low only while reset is asserted, so apart from reset the block never holds off a load. While `set_valid` is high, the prescaler and the tenths counter stay at zero. Line pulses arriving during that time therefore advance nothing.

Top module: `mains_tod_clock`

## Requirements
- R1: A synchronous active-high `rst` clears hours, minutes, seconds and tenths to 0 on the next edge, and `set_ready` is low exactly while `rst` is high.
- R2: A level on `line_in` that lasts fewer than `FILT_LEN` consecutive system-clock samples is rejected and advances no count.
- R3: Each accepted low-to-high transition of the filtered line produces exactly one count, however long the line then stays high.
- R4: With `mode_50hz` = 0, every 6 accepted line cycles advance `tenths` by one.
- R5: With `mode_50hz` = 1, every 5 accepted line cycles advance `tenths` by one.
- R6: `tenths` counts 0 to 9. On the step after 9 it returns to 0 and advances `seconds`.
- R7: `seconds` counts 0 to 59. On the step after 59 it returns to 0 and advances `minutes`.
- R8: `minutes` counts 0 to 59. On the step after 59 it returns to 0 and advances `hours`.
- R9: `hours` counts 0 to 23. From 23:59:59.9 the next tick gives 00:00:00.0.
- R10: An accepted load puts `set_hours`, `set_minutes` and `set_seconds` on the outputs one cycle later. The same load clears `tenths` and the prescaler's partial count, so a full prescaler period must follow before the next tenth.
- R11: A loaded hour above 23 becomes 23, and a loaded minute or second above 59 becomes 59.
- R12: Line pulses that arrive while `set_valid` is high change no time field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw pulse train taken from the AC line, asynchronous |
| mode_50hz | input | 1 | 1 selects divide-by-5 prescaling, 0 selects divide-by-6 |
| set_valid | input | 1 | Time-load request |
| set_ready | output | 1 | Load accepted when high together with set_valid (low only in reset) |
| set_hours | input | 5 | Hours value to load, binary |
| set_minutes | input | 6 | Minutes value to load, binary |
| set_seconds | input | 6 | Seconds value to load, binary |
| tenths | output | 4 | Tenths of a second, binary 0..9 |
| seconds | output | 6 | Seconds, binary 0..59 |
| minutes | output | 6 | Minutes, binary 0..59 |
| hours | output | 5 | Hours, binary 0..23 |

## Verification
The hardest case to reach is the midnight rollover. Counting up to it from reset would take millions of line cycles. The bench instead loads 23:59:59 through the set port and then supplies one second's worth of line pulses, so the full carry ripple is reached quickly. Carries into minutes and hours are reached the same way, from 00:00:59 and 00:59:59. The filter is exercised with sub-threshold spikes placed between genuine pulses. The tenths count is then checked at the pulse that should complete a prescaler period, so a single counted spike would show up as an early tenth.

// File: rtl/mains_tod_pkg.sv
package mains_tod_pkg;
  localparam int HR_W   = 5;
  localparam int MS_W   = 6;
  localparam int TN_W   = 4;
  localparam int HR_MOD = 24;
  localparam int MS_MOD = 60;
  localparam int TN_MOD = 10;
  localparam int DIV60  = 6;
  localparam int DIV50  = 5;
  localparam int PRE_W  = $clog2(DIV60);

  // Limit a loaded value to the largest legal count of its field.
  function automatic logic [MS_W-1:0] clamp_field(input logic [MS_W-1:0] v,
                                                  input logic [MS_W-1:0] maxv);
    return (v > maxv) ? maxv : v;
  endfunction
endpackage

// File: rtl/tod_line_filter.sv
module tod_line_filter #(
  parameter int FILT_LEN  = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_pulse
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  filt_q;
  logic                  filt_prev_q;
  logic [CW-1:0]         run_q;
  logic                  line_s;

  // Synchronizer chain, one stage per generate step.
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_DEPTH; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[gi] <= 1'b0;
          else     sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign line_s = sync_q[SYNC_DEPTH-1];

  // Persistence filter: a new level is taken only after FILT_LEN
  // consecutive samples disagree with the current filtered level.
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (line_s == filt_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      filt_q <= line_s;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) filt_prev_q <= 1'b0;
    else     filt_prev_q <= filt_q;
  end

  assign line_pulse = filt_q & ~filt_prev_q;
endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler
  import mains_tod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic mode_50,
  input  logic pulse_in,
  output logic tick_out
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;

  assign last     = mode_50 ? PRE_W'(DIV50 - 1) : PRE_W'(DIV60 - 1);
  // ">=" keeps a mode switch mid-period from overrunning the shorter divide.
  assign tick_out = pulse_in & ~clr & (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt_q <= '0;
    else if (tick_out) cnt_q <= '0;
    else if (pulse_in) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tod_digit.sv
module tod_digit #(
  parameter int MOD = 60,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carry
);
  logic [W-1:0] val_q;

  assign carry = inc & ~load & (val_q == W'(MOD - 1));
  assign value = val_q;

  always_ff @(posedge clk) begin
    if (rst)        val_q <= '0;
    else if (load)  val_q <= load_val;
    else if (carry) val_q <= '0;
    else if (inc)   val_q <= val_q + 1'b1;
  end
endmodule

// File: rtl/mains_tod_clock.sv
module mains_tod_clock
  import mains_tod_pkg::*;
#(
  parameter int FILT_LEN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_in,
  input  logic            mode_50hz,
  input  logic            set_valid,
  output logic            set_ready,
  input  logic [HR_W-1:0] set_hours,
  input  logic [MS_W-1:0] set_minutes,
  input  logic [MS_W-1:0] set_seconds,
  output logic [TN_W-1:0] tenths,
  output logic [MS_W-1:0] seconds,
  output logic [MS_W-1:0] minutes,
  output logic [HR_W-1:0] hours
);
  logic            line_pulse;
  logic            tenth_tick;
  logic            sec_tick;
  logic            min_tick;
  logic            hr_tick;
  logic            day_wrap;
  logic            load;
  logic [MS_W-1:0] ld_sec;
  logic [MS_W-1:0] ld_min;
  logic [MS_W-1:0] ld_hr_wide;
  logic [HR_W-1:0] ld_hr;

  assign set_ready = ~rst;
  assign load      = set_valid & set_ready;

  assign ld_sec     = clamp_field(set_seconds, MS_W'(MS_MOD - 1));
  assign ld_min     = clamp_field(set_minutes, MS_W'(MS_MOD - 1));
  assign ld_hr_wide = clamp_field(MS_W'(set_hours), MS_W'(HR_MOD - 1));
  assign ld_hr      = ld_hr_wide[HR_W-1:0];

  tod_line_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk        (clk),
    .rst        (rst),
    .line_raw   (line_in),
    .line_pulse (line_pulse)
  );

  tod_prescaler u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (set_valid),
    .mode_50  (mode_50hz),
    .pulse_in (line_pulse),
    .tick_out (tenth_tick)
  );

  tod_digit #(.MOD(TN_MOD), .W(TN_W)) u_tenths (
    .clk      (clk),
    .rst      (rst),
    .load     (set_valid),
    .load_val ('0),
    .inc      (tenth_tick),
    .value    (tenths),
    .carry    (sec_tick)
  );

  tod_digit #(.MOD(MS_MOD), .W(MS_W)) u_sec (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (ld_sec),
    .inc      (sec_tick),
    .value    (seconds),
    .carry    (min_tick)
  );

  tod_digit #(.MOD(MS_MOD), .W(MS_W)) u_min (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (ld_min),
    .inc      (min_tick),
    .value    (minutes),
    .carry    (hr_tick)
  );

  tod_digit #(.MOD(HR_MOD), .W(HR_W)) u_hr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (ld_hr),
    .inc      (hr_tick),
    .value    (hours),
    .carry    (day_wrap)
  );

  logic unused_ok;
  assign unused_ok = day_wrap;
endmodule

// File: rtl/mains_tod_checker.sv
module mains_tod_checker (
  input logic       clk,
  input logic       rst,
  input logic       set_valid,
  input logic       set_ready,
  input logic [4:0] set_hours,
  input logic [5:0] set_minutes,
  input logic [5:0] set_seconds,
  input logic [3:0] tenths,
  input logic [5:0] seconds,
  input logic [5:0] minutes,
  input logic [4:0] hours,
  input logic       line_pulse
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (hours == 5'd0 && minutes == 6'd0 && seconds == 6'd0 && tenths == 4'd0));

  a_r1_ready_in_reset: assert property (@(posedge clk)
    rst |-> !set_ready);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    line_pulse |=> !line_pulse);

  a_r6_tenths_range: assert property (@(posedge clk) disable iff (rst)
    tenths <= 4'd9);

  a_r7_seconds_range: assert property (@(posedge clk) disable iff (rst)
    seconds <= 6'd59);

  a_r8_minutes_range: assert property (@(posedge clk) disable iff (rst)
    minutes <= 6'd59);

  a_r9_hours_range: assert property (@(posedge clk) disable iff (rst)
    hours <= 5'd23);

  a_r7_seconds_step: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && !$past(set_valid) && $past(seconds) != 6'd59
     && !$stable(seconds)) |-> seconds == $past(seconds) + 6'd1);

  a_r10_tenths_clear: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_ready) |=> tenths == 4'd0);

  a_r11_sec_clamp: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_ready && set_seconds > 6'd59) |=> seconds == 6'd59);

  a_r11_hr_clamp: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_ready && set_hours > 5'd23) |=> hours == 5'd23);

  a_r10_load_min: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_ready && set_minutes <= 6'd59) |=> minutes == $past(set_minutes));
endmodule

bind mains_tod_clock mains_tod_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .set_valid   (set_valid),
  .set_ready   (set_ready),
  .set_hours   (set_hours),
  .set_minutes (set_minutes),
  .set_seconds (set_seconds),
  .tenths      (tenths),
  .seconds     (seconds),
  .minutes     (minutes),
  .hours       (hours),
  .line_pulse  (line_pulse)
);

// File: tb/tb_mains_tod_clock.sv
module tb_mains_tod_clock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_in = 1'b0;
  logic       mode_50hz = 1'b0;
  logic       set_valid = 1'b0;
  logic       set_ready;
  logic [4:0] set_hours = '0;
  logic [5:0] set_minutes = '0;
  logic [5:0] set_seconds = '0;
  logic [3:0] tenths;
  logic [5:0] seconds;
  logic [5:0] minutes;
  logic [4:0] hours;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  mains_tod_clock #(.FILT_LEN(4)) dut (
    .clk(clk), .rst(rst), .line_in(line_in), .mode_50hz(mode_50hz),
    .set_valid(set_valid), .set_ready(set_ready),
    .set_hours(set_hours), .set_minutes(set_minutes), .set_seconds(set_seconds),
    .tenths(tenths), .seconds(seconds), .minutes(minutes), .hours(hours)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_time(input string req, input int h, input int m, input int s, input int t);
    check_eq(req, "hours",   int'(hours),   h);
    check_eq(req, "minutes", int'(minutes), m);
    check_eq(req, "seconds", int'(seconds), s);
    check_eq(req, "tenths",  int'(tenths),  t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic line_cycles(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      line_in = 1'b1; idle(hi);
      line_in = 1'b0; idle(lo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; line_in = 1'b0; set_valid = 1'b0;
    idle(3);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic load_time(input int h, input int m, input int s);
    @(negedge clk);
    set_hours = 5'(h); set_minutes = 6'(m); set_seconds = 6'(s);
    set_valid = 1'b1;
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    idle(2);
    check_eq("R1", "set_ready in reset", int'(set_ready), 0);
    check_time("R1", 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "set_ready after reset", int'(set_ready), 1);
  endtask

  task automatic t_r4_div6();
    do_reset(); mode_50hz = 1'b0;
    line_cycles(5, 8, 8);
    check_eq("R4", "tenths after 5", int'(tenths), 0);
    line_cycles(1, 8, 8);
    check_eq("R4", "tenths after 6", int'(tenths), 1);
  endtask

  task automatic t_r5_div5();
    do_reset(); mode_50hz = 1'b1;
    line_cycles(4, 8, 8);
    check_eq("R5", "tenths after 4", int'(tenths), 0);
    line_cycles(1, 8, 8);
    check_eq("R5", "tenths after 5", int'(tenths), 1);
  endtask

  task automatic t_r2_glitch();
    do_reset(); mode_50hz = 1'b1;
    line_cycles(4, 8, 8);
    line_cycles(10, 2, 10);
    check_eq("R2", "tenths after spikes", int'(tenths), 0);
    line_cycles(1, 8, 8);
    check_eq("R2", "tenths after 5th real pulse", int'(tenths), 1);
  endtask

  task automatic t_r3_long_high();
    do_reset(); mode_50hz = 1'b1;
    line_cycles(4, 200, 200);
    check_eq("R3", "tenths after 4 long", int'(tenths), 0);
    line_cycles(1, 200, 200);
    check_eq("R3", "tenths after 5 long", int'(tenths), 1);
  endtask

  task automatic t_r6_tenths_wrap();
    do_reset(); mode_50hz = 1'b1;
    load_time(0, 0, 5);
    line_cycles(45, 8, 8);
    check_time("R6", 0, 0, 5, 9);
    line_cycles(5, 8, 8);
    check_time("R6", 0, 0, 6, 0);
  endtask

  task automatic t_r7_sec_wrap();
    do_reset(); mode_50hz = 1'b1;
    load_time(0, 0, 59);
    line_cycles(50, 8, 8);
    check_time("R7", 0, 1, 0, 0);
  endtask

  task automatic t_r8_min_wrap();
    do_reset(); mode_50hz = 1'b0;
    load_time(0, 59, 59);
    line_cycles(60, 8, 8);
    check_time("R8", 1, 0, 0, 0);
  endtask

  task automatic t_r9_midnight();
    do_reset(); mode_50hz = 1'b1;
    load_time(23, 59, 59);
    line_cycles(45, 8, 8);
    check_time("R9", 23, 59, 59, 9);
    line_cycles(5, 8, 8);
    check_time("R9", 0, 0, 0, 0);
  endtask

  task automatic t_r10_load();
    do_reset(); mode_50hz = 1'b1;
    line_cycles(13, 8, 8);
    check_eq("R10", "tenths before load", int'(tenths), 2);
    load_time(12, 34, 56);
    check_time("R10", 12, 34, 56, 0);
    line_cycles(4, 8, 8);
    check_eq("R10", "prescaler cleared", int'(tenths), 0);
    line_cycles(1, 8, 8);
    check_eq("R10", "tenth after full period", int'(tenths), 1);
  endtask

  task automatic t_r11_clamp();
    do_reset();
    load_time(31, 63, 60);
    check_time("R11", 23, 59, 59, 0);
  endtask

  task automatic t_r12_hold();
    do_reset(); mode_50hz = 1'b1;
    @(negedge clk);
    set_hours = 5'd7; set_minutes = 6'd8; set_seconds = 6'd9;
    set_valid = 1'b1;
    line_cycles(20, 8, 8);
    check_time("R12", 7, 8, 9, 0);
    set_valid = 1'b0;
    line_cycles(4, 8, 8);
    check_time("R12", 7, 8, 9, 0);
  endtask

  initial begin
    idle(4);
    t_reset();
    t_r4_div6();
    t_r5_div5();
    t_r2_glitch();
    t_r3_long_high();
    t_r6_tenths_wrap();
    t_r7_sec_wrap();
    t_r8_min_wrap();
    t_r9_midnight();
    t_r10_load();
    t_r11_clamp();
    t_r12_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule